// File: doc/BRIEF.md
# Load-Use Interlock and Branch Flush Control

This block sits beside the decode stage of a five-stage in-order pipeline and decides, every cycle, whether the front end may advance. It compares the destination register of the instruction now between decode and execute against both source fields of the instruction now between fetch and decode. If the older instruction is a memory read whose destination is a real register (not register zero) and one of those fields names it, the younger instruction cannot yet obtain its operand, even through forwarding. The block then holds the program counter and the fetch/decode register and inserts an empty slot into decode/execute. The load still moves on, so after exactly one lost cycle the loaded value can be forwarded.

The same block drives the flush for a branch that a comparator in decode has found taken. That flush clears the fetch/decode register, so the single instruction fetched behind the branch becomes a no-op and a taken branch costs one cycle. If a stall and a taken branch are requested in the same cycle, the stall wins and no flush is issued. The branch stays frozen in fetch/decode, and its comparator result is taken again in the following cycle, once the empty slot has entered execute.

All outputs are combinational from the present inputs. The pipeline registers they steer take them at the next clock edge. A synchronous reset input forces every output low while it is held.

Top module: `hazard_ctl`

## Requirements
- R1: When `dx_mem_rd` is 1, `dx_dst` is nonzero and `dx_dst` equals `fd_rs`, the outputs `{pc_we, fd_we, dx_bubble, fd_flush}` are `0010` in that cycle.
- R2: When no stall condition holds and `br_taken` is 0, the outputs `{pc_we, fd_we, dx_bubble, fd_flush}` are `1100`. This covers a load whose destination matches neither source field.
- R3: A load whose destination is register 0 never raises a stall, even when a source field is also 0.
- R4: An instruction in decode/execute with `dx_mem_rd` 0 never raises a stall, even when its destination matches a source field.
- R5: A taken branch with no stall gives outputs `1101`: the front end advances and fetch/decode is cleared.
- R6: When a stall and `br_taken` coincide, the outputs are `0010` and `fd_flush` stays 0. In the next cycle, with the empty slot in decode/execute and `br_taken` still 1, the outputs are `1101`.
- R7: While `rst` is 1, all four outputs are 0, whatever the other inputs are.
- R8: A match on `fd_rt` alone raises the same stall as a match on `fd_rs`.
- R9: A single load-use case stalls for exactly one cycle. In the cycle after the stall, the inserted empty slot (memory read 0) is in decode/execute and the outputs return to `1100`.
- R10: `pc_we` and `fd_we` are always equal, and `dx_bubble` is never 1 in the same cycle as `fd_flush`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used only to sample the embedded checks |
| rst | input | 1 | Synchronous reset; when 1, all outputs are forced low |
| dx_mem_rd | input | 1 | Memory-read flag of the decode/execute instruction |
| dx_dst | input | REG_AW | Destination register of the decode/execute instruction |
| fd_rs | input | REG_AW | First source field of the fetch/decode instruction |
| fd_rt | input | REG_AW | Second source field of the fetch/decode instruction |
| br_taken | input | 1 | Decode-stage comparator reports a taken branch |
| pc_we | output | 1 | Program counter write enable |
| fd_we | output | 1 | Fetch/decode register write enable |
| dx_bubble | output | 1 | Selects all-zero control fields into decode/execute |
| fd_flush | output | 1 | Clears the fetch/decode register at the next edge |

## Verification
The one-cycle stall check assumes the surrounding pipeline obeys `dx_bubble`. In the cycle after a stall, decode/execute must hold the empty slot, so `dx_mem_rd` is 0 there. A comparator that is re-evaluated after a frozen branch is also expected to report the same result again. The directed stimulus acts as that pipeline. After each stall it clears the memory-read flag in the next cycle and keeps the frozen source fields and branch outcome unchanged, so no check sees an input sequence that a real pipeline could not produce.

// File: rtl/hazard_ctl.sv
`timescale 1ns/1ps
module hazard_ctl #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dx_mem_rd,
  input  logic [REG_AW-1:0] dx_dst,
  input  logic [REG_AW-1:0] fd_rs,
  input  logic [REG_AW-1:0] fd_rt,
  input  logic              br_taken,
  output logic              pc_we,
  output logic              fd_we,
  output logic              dx_bubble,
  output logic              fd_flush
);

  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic dst_live, src_hit, load_use;

  assign dst_live = dx_mem_rd && (dx_dst != ZERO_REG);
  assign src_hit  = (dx_dst == fd_rs) || (dx_dst == fd_rt);
  assign load_use = dst_live && src_hit;

  assign pc_we     = !rst && !load_use;
  assign fd_we     = !rst && !load_use;
  assign dx_bubble = !rst && load_use;
  assign fd_flush  = !rst && br_taken && !load_use;

  a_r1_rs_match_stalls: assert property (@(posedge clk) disable iff (rst)
    (dx_mem_rd && dx_dst != '0 && dx_dst == fd_rs) |-> (!pc_we && !fd_we && dx_bubble));

  a_r8_rt_match_stalls: assert property (@(posedge clk) disable iff (rst)
    (dx_mem_rd && dx_dst != '0 && dx_dst == fd_rt) |-> (!pc_we && dx_bubble));

  a_r3_zero_dest_free: assert property (@(posedge clk) disable iff (rst)
    (dx_dst == '0) |-> !dx_bubble);

  a_r4_non_load_free: assert property (@(posedge clk) disable iff (rst)
    !dx_mem_rd |-> (pc_we && fd_we && !dx_bubble));

  a_r5_branch_flush: assert property (@(posedge clk) disable iff (rst)
    (br_taken && pc_we) |-> fd_flush);

  a_r6_stall_wins: assert property (@(posedge clk) disable iff (rst)
    dx_bubble |-> !fd_flush);

  a_r9_single_bubble: assert property (@(posedge clk) disable iff (rst)
    dx_bubble |=> !dx_bubble);

  a_r10_enables_agree: assert property (@(posedge clk) disable iff (rst)
    pc_we == fd_we);

  a_r7_reset_quiet: assert property (@(posedge clk)
    rst |-> (!pc_we && !fd_we && !dx_bubble && !fd_flush));

endmodule

// File: tb/hazard_ctl_bench.sv
`timescale 1ns/1ps
module hazard_ctl_bench;
  localparam int AW = 5;
  localparam logic [3:0] RUN = 4'b1100, STALL = 4'b0010, FLUSH = 4'b1101, QUIET = 4'b0000;

  logic clk = 1'b0, rst = 1'b1, mem_rd = 1'b0, br = 1'b0;
  logic [AW-1:0] dst = '0, rs = '0, rt = '0;
  logic pc_we, fd_we, bub, fl;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hazard_ctl #(.REG_AW(AW)) u_hazard_ctl (
    .clk(clk), .rst(rst), .dx_mem_rd(mem_rd), .dx_dst(dst),
    .fd_rs(rs), .fd_rt(rt), .br_taken(br),
    .pc_we(pc_we), .fd_we(fd_we), .dx_bubble(bub), .fd_flush(fl));

  task automatic drive(input logic m, input logic [AW-1:0] d, input logic [AW-1:0] s,
                       input logic [AW-1:0] t, input logic b);
    @(negedge clk);
    mem_rd = m; dst = d; rs = s; rt = t; br = b;
    #1;
  endtask

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {pc_we, fd_we, bub, fl};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic t_reset();
    drive(1'b1, 5'd3, 5'd3, 5'd3, 1'b1);
    chk("R7 reset with hazard and branch", QUIET);
    @(negedge clk); rst = 1'b0;
    drive(1'b0, 5'd0, 5'd0, 5'd0, 1'b0);
    chk("R2 idle after reset", RUN);
  endtask

  task automatic t_load_dep_rs();
    drive(1'b1, 5'd7, 5'd7, 5'd2, 1'b0);
    chk("R1 load dest equals rs", STALL);
    drive(1'b0, 5'd0, 5'd7, 5'd2, 1'b0);
    chk("R9 bubble cycle releases", RUN);
  endtask

  task automatic t_load_dep_rt();
    drive(1'b1, 5'd31, 5'd4, 5'd31, 1'b0);
    chk("R8 load dest equals rt", STALL);
    drive(1'b0, 5'd0, 5'd4, 5'd31, 1'b0);
    chk("R9 release after rt stall", RUN);
  endtask

  task automatic t_load_indep();
    drive(1'b1, 5'd9, 5'd8, 5'd10, 1'b0);
    chk("R2 independent load", RUN);
    drive(1'b1, 5'd1, 5'd2, 5'd3, 1'b0);
    chk("R2 second independent load", RUN);
  endtask

  task automatic t_load_r0();
    drive(1'b1, 5'd0, 5'd0, 5'd5, 1'b0);
    chk("R3 load to r0, rs r0", RUN);
    drive(1'b1, 5'd0, 5'd6, 5'd0, 1'b1);
    chk("R3 load to r0, rt r0, branch", FLUSH);
  endtask

  task automatic t_alu_match();
    drive(1'b0, 5'd12, 5'd12, 5'd12, 1'b0);
    chk("R4 non-load matching dest", RUN);
  endtask

  task automatic t_branch();
    drive(1'b0, 5'd3, 5'd1, 5'd2, 1'b1);
    chk("R5 taken branch flush", FLUSH);
    drive(1'b0, 5'd0, 5'd1, 5'd2, 1'b0);
    chk("R5 flush lasts one cycle", RUN);
  endtask

  task automatic t_branch_stall();
    drive(1'b1, 5'd6, 5'd6, 5'd1, 1'b1);
    chk("R6 stall beats flush", STALL);
    drive(1'b0, 5'd0, 5'd6, 5'd1, 1'b1);
    chk("R6 branch flushes after bubble", FLUSH);
    drive(1'b0, 5'd0, 5'd0, 5'd0, 1'b0);
    chk("R10 steady run", RUN);
  endtask

  initial begin
    t_reset();
    t_load_dep_rs();
    t_load_dep_rt();
    t_load_indep();
    t_load_r0();
    t_alu_match();
    t_branch();
    t_branch_stall();
    @(negedge clk); rst = 1'b1; #1;
    chk("R7 reset reasserted", QUIET);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule